// File: doc/BRIEF.md
# Core Idle-State Sequencer

This block walks a single processor core between its run state and three idle depths: a halt that keeps clocks and coherence snooping alive, a deep state with caches written back and clocks stopped, and a power-gated state in which the architectural context lives in an on-chip save memory and the supply is removed. A halt or monitor-wait request names a target depth. Each deeper step is a handshake with an outside agent: the cache hierarchy for the write-back, the save memory for context save and restore, and the regulator, which simply follows the voltage enable.

An interrupt (the wake input) brings the core back to running. Wake from a settled deep state undoes the entry steps in reverse order. A wake during an entry stops at the step in progress and undoes only the steps already taken. The current settled depth is reported as 0, 1, 3 or 6, and a busy flag marks every cycle spent in a transition.

Top module: `core_idle_seq`

## Requirements
- R1: After reset the core is running: clock enable, snoop enable and voltage enable high, all requests low, busy low, current state 0.
- R2: In the running state an idle request with target code 1 or 2 (code 2 is rounded down) moves the block, one clock later, to the halt state: current state 1, clock enable and snoop enable still high, busy low. A wake returns it to running one clock later.
- R3: When the halt request carries the low-frequency hint, the low-frequency request output is high for exactly the cycles spent in the halt state and never in any other state.
- R4: Target code 3 raises the flush request with busy high while clocks and snoops stay enabled. The cycle after flush-done is seen, the block settles at current state 3 with clock enable and snoop enable low and voltage still on.
- R5: A wake in state 3 produces one busy cycle with the clock enabled but snoops still blocked, then the running state; no save or restore request is raised.
- R6: Target code 6 performs the R4 write-back, then holds the save request with clocks stopped until save-done; only on the following cycle does the voltage enable fall, at current state 6.
- R7: A wake in state 6 raises the voltage enable first, holds it for SETTLE_CYC cycles with nothing else requested, then holds the restore request until restore-done, then enables the clock for one cycle with snoops blocked, then returns to running.
- R8: A wake during the write-back drops the flush request and returns to running on the next clock.
- R9: A wake while the save is pending drops the save request, keeps the voltage on, and returns through the clock-on/snoop-off cycle to running without a restore.
- R10: Target codes 0, 4, 5 and 7 are ignored, and idle requests made in any state other than running are ignored.
- R11: An idle request in the same cycle as a wake is ignored; the block stays running.
- R12: Busy is high only while current state reads 0, and current state only ever takes the values 0, 1, 3 or 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idle_req | input | 1 | Halt or monitor-wait request, sampled for one cycle |
| idle_target | input | 3 | Requested depth code (1, 2, 3 or 6 accepted) |
| lowfreq_hint | input | 1 | Halt request asks for the lowest operating point |
| wake | input | 1 | Interrupt or wake event |
| flush_done | input | 1 | Cache write-back complete |
| save_done | input | 1 | Context save complete |
| restore_done | input | 1 | Context restore complete |
| clk_en | output | 1 | Core clock enable |
| snoop_en | output | 1 | Core accepts coherence snoops |
| flush_req | output | 1 | Cache write-back request |
| save_req | output | 1 | Context save request |
| restore_req | output | 1 | Context restore request |
| vdd_on | output | 1 | Core supply enable to the regulator |
| lowfreq_req | output | 1 | Low operating point request to an external arbiter |
| busy | output | 1 | A transition is in progress |
| cstate | output | 3 | Settled depth: 0, 1, 3 or 6 |

## Verification
Each depth is driven with the full entry handshake and a settled wake, so the halt, deep and gated paths are told apart by which of the clock, snoop, flush, save and voltage outputs move and in which order. Requests with the hint set and cleared show that the low-frequency output belongs to the halt alone. Wakes injected during the write-back and during the save separate a full reverse walk from a partial unwind, and unsupported codes, requests outside the running state and request-with-wake collisions show that nothing starts when it should not.

// File: rtl/core_idle_seq.sv
module core_idle_seq #(
  parameter int SETTLE_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idle_req,
  input  logic [2:0] idle_target,
  input  logic       lowfreq_hint,
  input  logic       wake,
  input  logic       flush_done,
  input  logic       save_done,
  input  logic       restore_done,
  output logic       clk_en,
  output logic       snoop_en,
  output logic       flush_req,
  output logic       save_req,
  output logic       restore_req,
  output logic       vdd_on,
  output logic       lowfreq_req,
  output logic       busy,
  output logic [2:0] cstate
);
  localparam int CW = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(SETTLE_CYC - 1);

  typedef enum logic [3:0] {
    S_RUN, S_HALT, S_FLUSH, S_DEEP, S_SAVE, S_GATED, S_VUP, S_RESTORE, S_UNGATE
  } st_t;

  st_t st;
  logic to_gated, lf_q;
  logic [CW-1:0] cnt;
  logic start;

  assign start = idle_req && !wake;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_RUN;
      to_gated <= 1'b0;
      lf_q <= 1'b0;
      cnt <= '0;
    end else begin
      case (st)
        S_RUN:
          if (start) begin
            case (idle_target)
              3'd1, 3'd2: begin st <= S_HALT; lf_q <= lowfreq_hint; end
              3'd3: begin st <= S_FLUSH; to_gated <= 1'b0; end
              3'd6: begin st <= S_FLUSH; to_gated <= 1'b1; end
              default: ;
            endcase
          end
        S_HALT:
          if (wake) begin st <= S_RUN; lf_q <= 1'b0; end
        S_FLUSH:
          if (wake) st <= S_RUN;
          else if (flush_done) st <= to_gated ? S_SAVE : S_DEEP;
        S_DEEP:
          if (wake) st <= S_UNGATE;
        S_SAVE:
          if (wake) st <= S_UNGATE;
          else if (save_done) st <= S_GATED;
        S_GATED:
          if (wake) begin st <= S_VUP; cnt <= '0; end
        S_VUP:
          if (cnt == CNT_LAST) st <= S_RESTORE;
          else cnt <= cnt + 1'b1;
        S_RESTORE:
          if (restore_done) st <= S_UNGATE;
        S_UNGATE:
          st <= S_RUN;
        default:
          st <= S_RUN;
      endcase
    end
  end

  assign clk_en      = st inside {S_RUN, S_HALT, S_FLUSH, S_UNGATE};
  assign snoop_en    = st inside {S_RUN, S_HALT, S_FLUSH};
  assign flush_req   = st == S_FLUSH;
  assign save_req    = st == S_SAVE;
  assign restore_req = st == S_RESTORE;
  assign vdd_on      = st != S_GATED;
  assign lowfreq_req = (st == S_HALT) && lf_q;
  assign busy        = st inside {S_FLUSH, S_SAVE, S_VUP, S_RESTORE, S_UNGATE};
  assign cstate      = (st == S_HALT)  ? 3'd1 :
                       (st == S_DEEP)  ? 3'd3 :
                       (st == S_GATED) ? 3'd6 : 3'd0;
endmodule

// File: rtl/core_idle_seq_chk.sv
module core_idle_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       flush_done,
  input logic       save_done,
  input logic       clk_en,
  input logic       snoop_en,
  input logic       save_req,
  input logic       restore_req,
  input logic       vdd_on,
  input logic       lowfreq_req,
  input logic       busy,
  input logic [2:0] cstate
);
  assert_lowfreq_only_halt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lowfreq_req |-> cstate == 3'd1);

  assert_clock_stops_after_flush_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_en) |-> $past(flush_done));

  assert_vdd_drops_after_save_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vdd_on) |-> $past(save_done));

  assert_save_clocks_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    save_req |-> (!clk_en && vdd_on));

  assert_restore_powered_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    restore_req |-> (vdd_on && !clk_en && !snoop_en));

  assert_snoop_after_clock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(snoop_en) |-> $past(clk_en));

  assert_busy_state_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cstate == 3'd0);

  assert_state_codes_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cstate inside {3'd0, 3'd1, 3'd3, 3'd6});
endmodule

bind core_idle_seq core_idle_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .flush_done(flush_done), .save_done(save_done),
  .clk_en(clk_en), .snoop_en(snoop_en), .save_req(save_req),
  .restore_req(restore_req), .vdd_on(vdd_on), .lowfreq_req(lowfreq_req),
  .busy(busy), .cstate(cstate)
);

// File: tb/core_idle_seq_test.sv
module core_idle_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE = 4;

  logic clk = 0, rst_n = 0;
  logic idle_req = 0, lowfreq_hint = 0, wake = 0;
  logic flush_done = 0, save_done = 0, restore_done = 0;
  logic [2:0] idle_target = 0;
  logic clk_en, snoop_en, flush_req, save_req, restore_req, vdd_on, lowfreq_req, busy;
  logic [2:0] cstate;

  int checks = 0, failures = 0, cycles = 0;
  logic [10:0] qv[$];
  string qt[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  core_idle_seq #(.SETTLE_CYC(SETTLE)) uut (
    .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .idle_target(idle_target),
    .lowfreq_hint(lowfreq_hint), .wake(wake), .flush_done(flush_done),
    .save_done(save_done), .restore_done(restore_done), .clk_en(clk_en),
    .snoop_en(snoop_en), .flush_req(flush_req), .save_req(save_req),
    .restore_req(restore_req), .vdd_on(vdd_on), .lowfreq_req(lowfreq_req),
    .busy(busy), .cstate(cstate)
  );

  function automatic logic [10:0] ov(bit ce, bit sn, bit fl, bit sv, bit rs,
                                     bit vd, bit lf, bit bz, int cs);
    return {ce, sn, fl, sv, rs, vd, lf, bz, 3'(cs)};
  endfunction

  localparam logic [10:0] RUN_V  = {8'b11000100, 3'd0};
  localparam logic [10:0] HALT_V = {8'b11000100, 3'd1};
  localparam logic [10:0] HLF_V  = {8'b11000110, 3'd1};
  localparam logic [10:0] FL_V   = {8'b11100101, 3'd0};
  localparam logic [10:0] DEEP_V = {8'b00000100, 3'd3};
  localparam logic [10:0] SV_V   = {8'b00010101, 3'd0};
  localparam logic [10:0] GT_V   = {8'b00000000, 3'd6};
  localparam logic [10:0] VUP_V  = {8'b00000101, 3'd0};
  localparam logic [10:0] RS_V   = {8'b00001101, 3'd0};
  localparam logic [10:0] UG_V   = {8'b10000101, 3'd0};

  task automatic step(input logic [10:0] e, input string tag);
    @(posedge clk); #1;
    qv.push_back(e);
    qt.push_back(tag);
  endtask

  task automatic request(input int tgt, input bit lf);
    idle_req = 1; idle_target = 3'(tgt); lowfreq_hint = lf;
  endtask

  task automatic clear_inputs();
    idle_req = 0; idle_target = 0; lowfreq_hint = 0; wake = 0;
    flush_done = 0; save_done = 0; restore_done = 0;
  endtask

  always @(negedge clk) begin
    if (qv.size() > 0) begin
      logic [10:0] e, a;
      string t;
      e = qv.pop_front();
      t = qt.pop_front();
      a = {clk_en, snoop_en, flush_req, save_req, restore_req, vdd_on,
           lowfreq_req, busy, cstate};
      checks++;
      if (a !== e) begin
        failures++;
        $display("FAIL %s actual=%b expected=%b", t, a, e);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<=5000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    step(RUN_V, "R1 in reset");
    rst_n = 1;
    step(RUN_V, "R1 after reset");

    request(1, 0); step(HALT_V, "R2 code1 halt"); clear_inputs();
    step(HALT_V, "R2 halt holds");
    wake = 1; step(RUN_V, "R2 wake from halt"); clear_inputs();

    request(2, 0); step(HALT_V, "R2 code2 rounds to halt"); clear_inputs();
    request(6, 0); step(HALT_V, "R10 request in halt ignored"); clear_inputs();
    wake = 1; step(RUN_V, "R2 wake"); clear_inputs();

    request(1, 1); step(HLF_V, "R3 lowfreq in halt"); clear_inputs();
    step(HLF_V, "R3 lowfreq holds");
    wake = 1; step(RUN_V, "R3 lowfreq drops on wake"); clear_inputs();

    for (int c = 0; c < 8; c++) begin
      if (c == 0 || c == 4 || c == 5 || c == 7) begin
        request(c, 0); step(RUN_V, "R10 unsupported code ignored"); clear_inputs();
      end
    end

    request(3, 0); wake = 1; step(RUN_V, "R11 wake beats request"); clear_inputs();

    request(3, 1); step(FL_V, "R4 flush requested"); clear_inputs();
    step(FL_V, "R4 flush pending clocks on");
    flush_done = 1; step(DEEP_V, "R4 settled deep"); clear_inputs();
    request(1, 0); step(DEEP_V, "R10 request in deep ignored"); clear_inputs();
    wake = 1; step(UG_V, "R5 clock on snoop off"); clear_inputs();
    step(RUN_V, "R5 back to run");

    request(6, 0); step(FL_V, "R6 flush first"); clear_inputs();
    flush_done = 1; step(SV_V, "R6 save clocks off"); clear_inputs();
    step(SV_V, "R6 save pending voltage on");
    save_done = 1; step(GT_V, "R6 voltage off"); clear_inputs();
    step(GT_V, "R6 gated holds");
    wake = 1; step(VUP_V, "R7 voltage first"); clear_inputs();
    for (int i = 1; i < SETTLE; i++) step(VUP_V, "R7 settle window");
    step(RS_V, "R7 restore after settle");
    step(RS_V, "R7 restore pending");
    restore_done = 1; step(UG_V, "R7 clock before snoop"); clear_inputs();
    step(RUN_V, "R7 back to run");

    request(3, 0); step(FL_V, "R8 flush started"); clear_inputs();
    wake = 1; step(RUN_V, "R8 abort in flush"); clear_inputs();
    step(RUN_V, "R8 stays run");

    request(6, 0); step(FL_V, "R9 flush"); clear_inputs();
    flush_done = 1; step(SV_V, "R9 save"); clear_inputs();
    wake = 1; step(UG_V, "R9 abort save no restore"); clear_inputs();
    step(RUN_V, "R9 back to run");

    repeat (2) @(posedge clk);
    @(negedge clk); #1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule